// File: doc/BRIEF.md
# Dual USB PHY Power Sequencer

This block replaces the firmware routine that powers two USB 2.0 PHY ports up and down. One port serves the device/OTG controller and the other serves the host controller. The block owns four outputs: a power control word, a two-bit clock-select field, a reset control word and a two-bit isolation vector. Each of these is a register that it reads, modifies and writes.

A power-on request starts a fixed bring-up:

1. Release the port's isolation.
2. Program the clock-select field from the reference rate.
3. Clear the port's power bits.
4. Pulse the port's reset bits.
5. Wait a settle time, then pulse `done`.

A power-off request sets the port's power bits first and then isolates the port. The reset pulse and the settle wait are both timed in pulses of a clock-enable tick whose frequency is a parameter. Each count is rounded up, so neither wait can be shorter than its nominal microseconds.

Requests are pulses and are held until they are served. The device port wins when both ports have work pending. If a power-on request carries a reference rate that has no encoding, the block raises a one-cycle error and leaves every output word as it was.

Top module: `usbphy_seq`

## Requirements
- R1: A power-on programs the clock-select output from the reference rate in MHz: 48 gives 0, 12 gives 2, 24 gives 3.
- R2: A power-on request with any other rate raises `rateErr` for one cycle. It produces no `done`, leaves all four output words unchanged and is then dropped.
- R3: The device port's power group is bits 0, 3 and 4 of `pwrWord`. Power-on clears these bits and power-off sets them.
- R4: The host port's power group is bits 6 and 7 of `pwrWord`. Power-on clears these bits and power-off sets them.
- R5: The reset group is bit 0 of `rstWord` for the device port, and bits 3 and 4 for the host port. Reset bits are only ever nonzero while `busy` is high, and only after the port's power group has been cleared. They are zero again when `done` is high.
- R6: `isoOut` bit 0 belongs to the device port and bit 1 to the host port, and 1 means released. Isolation is released before any power bit clears, and it is restored only after all of the port's power bits are set. A port with any power bit clear therefore always has its isolation released.
- R7: Reset stays asserted for exactly RST_TICKS+1 tick pulses, where RST_TICKS = ceil(RST_US·TICK_HZ/10^6). After reset is released, `done` follows after exactly SETTLE_TICKS+1 further tick pulses, where SETTLE_TICKS = ceil(SETTLE_US·TICK_HZ/10^6).
- R8: An operation changes only the selected port's bits in `pwrWord`, `rstWord` and `isoOut`. The other port's bits keep their values.
- R9: A request that arrives while a sequence is running is held and served after `done`. When both ports have work pending, the device port (index 0) is served first.
- R10: After reset, `pwrWord` is 8'hD9, `rstWord` is 0, `isoOut` is 0, `clkSel` is 0, and `busy`, `done` and `rateErr` are low.
- R11: If a power-on and a power-off request for the same port arrive in the same cycle, the power-off is kept and the power-on is discarded.
- R12: `done` is a single-cycle pulse and `busy` is high during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timing tick at TICK_HZ, one cycle wide |
| rateMhz | input | 8 | Reference clock rate in MHz |
| onReq | input | 2 | Power-on request pulse per port (0 device, 1 host) |
| offReq | input | 2 | Power-off request pulse per port |
| busy | output | 1 | A sequence or error cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rateErr | output | 1 | One-cycle pulse: power-on rejected for bad rate |
| pwrWord | output | 8 | Power control word, set bits power down |
| clkSel | output | 2 | Reference clock-select field |
| rstWord | output | 5 | Reset control word, set bits hold reset |
| isoOut | output | 2 | Isolation vector, 1 releases a port |

## Verification
The two functions that can collide in one cycle are request capture and request service. A new request can land on the same edge that a sequence finishes or that the arbiter picks a pending port. Both ports can also ask for work, or one port can ask for both directions, on a single edge. The bench provokes each case:

- It pulses the host request partway through a device bring-up.
- It pulses both ports at once.
- It raises power-on and power-off together for one port.

It judges each case by the order in which `done` pulses arrive and by the words visible at each `done`. These are compared against a bench model that applies the port masks in the expected order.

// File: rtl/usbphy_pkg.sv
package usbphy_pkg;

  typedef enum logic {
    PORT_DEV  = 1'b0,
    PORT_HOST = 1'b1
  } port_e;

  typedef struct packed {
    port_e port;
    logic  start;      // capture rate code
    logic  isoRel;
    logic  isoSet;
    logic  clkLoad;
    logic  pwrClr;
    logic  pwrSet;
    logic  rstSet;
    logic  rstClr;
    logic  loadRst;
    logic  loadSettle;
  } seqStb_t;

  function automatic logic [7:0] pwrMask(port_e p);
    return (p == PORT_DEV) ? 8'b0001_1001 : 8'b1100_0000;
  endfunction

  function automatic logic [4:0] rstMask(port_e p);
    return (p == PORT_DEV) ? 5'b00001 : 5'b11000;
  endfunction

  function automatic logic rateOk(logic [7:0] mhz);
    return (mhz == 8'd48) || (mhz == 8'd12) || (mhz == 8'd24);
  endfunction

  function automatic logic [1:0] rateCode(logic [7:0] mhz);
    case (mhz)
      8'd12:   return 2'd2;
      8'd24:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/usbphy_ctrl.sv
module usbphy_ctrl
  import usbphy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] rateMhz,
  input  logic [1:0] onReq,
  input  logic [1:0] offReq,
  input  logic       cntZero,
  output seqStb_t    stb,
  output logic       busy,
  output logic       done,
  output logic       rateErr
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISO, ST_CLK, ST_PWR, ST_RST_ON, ST_RST_HOLD,
    ST_SETTLE, ST_OFF_PWR, ST_OFF_ISO, ST_FIN, ST_ERR
  } state_e;

  state_e     state, stateNxt;
  port_e      selPort, selPortNxt;
  logic [1:0] pendOn, pendOff;
  logic [1:0] clrMask;
  logic [1:0] pendOnNxt, pendOffNxt;
  logic       pickValid, pickOn;
  port_e      pickPort;

  // device port has priority over host
  always_comb begin
    pickValid = 1'b0;
    pickOn    = 1'b0;
    pickPort  = PORT_DEV;
    if (pendOn[0] || pendOff[0]) begin
      pickValid = 1'b1;
      pickOn    = pendOn[0];
      pickPort  = PORT_DEV;
    end else if (pendOn[1] || pendOff[1]) begin
      pickValid = 1'b1;
      pickOn    = pendOn[1];
      pickPort  = PORT_HOST;
    end
  end

  always_comb begin
    stateNxt   = state;
    selPortNxt = selPort;
    clrMask    = 2'b00;
    stb        = '0;
    stb.port   = selPort;
    unique case (state)
      ST_IDLE: if (pickValid) begin
        clrMask[pickPort] = 1'b1;
        selPortNxt        = pickPort;
        if (pickOn && !rateOk(rateMhz)) stateNxt = ST_ERR;
        else if (pickOn) begin
          stateNxt  = ST_ISO;
          stb.start = 1'b1;
        end else stateNxt = ST_OFF_PWR;
      end
      ST_ISO:    begin stb.isoRel  = 1'b1; stateNxt = ST_CLK;    end
      ST_CLK:    begin stb.clkLoad = 1'b1; stateNxt = ST_PWR;    end
      ST_PWR:    begin stb.pwrClr  = 1'b1; stateNxt = ST_RST_ON; end
      ST_RST_ON: begin
        stb.rstSet  = 1'b1;
        stb.loadRst = 1'b1;
        stateNxt    = ST_RST_HOLD;
      end
      ST_RST_HOLD: if (tickEn && cntZero) begin
        stb.rstClr     = 1'b1;
        stb.loadSettle = 1'b1;
        stateNxt       = ST_SETTLE;
      end
      ST_SETTLE:  if (tickEn && cntZero) stateNxt = ST_FIN;
      ST_OFF_PWR: begin stb.pwrSet = 1'b1; stateNxt = ST_OFF_ISO; end
      ST_OFF_ISO: begin stb.isoSet = 1'b1; stateNxt = ST_FIN;     end
      ST_FIN:     stateNxt = ST_IDLE;
      ST_ERR:     stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  // new requests override the opposite pending request; off wins a tie
  always_comb begin
    pendOnNxt  = pendOn  & ~clrMask;
    pendOffNxt = pendOff & ~clrMask;
    for (int i = 0; i < 2; i++) begin
      if (offReq[i]) begin
        pendOffNxt[i] = 1'b1;
        pendOnNxt[i]  = 1'b0;
      end else if (onReq[i]) begin
        pendOnNxt[i]  = 1'b1;
        pendOffNxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selPort <= PORT_DEV;
      pendOn  <= '0;
      pendOff <= '0;
    end else begin
      state   <= stateNxt;
      selPort <= selPortNxt;
      pendOn  <= pendOnNxt;
      pendOff <= pendOffNxt;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign rateErr = (state == ST_ERR);

endmodule

// File: rtl/usbphy_dp.sv
module usbphy_dp
  import usbphy_pkg::*;
#(
  parameter int RST_TICKS    = 10,
  parameter int SETTLE_TICKS = 80,
  parameter int CNT_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  seqStb_t    stb,
  input  logic [7:0] rateMhz,
  output logic       cntZero,
  output logic [7:0] pwrWord,
  output logic [1:0] clkSel,
  output logic [4:0] rstWord,
  output logic [1:0] isoOut
);

  logic [1:0]       codeHeld;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       pMask;
  logic [4:0]       rMask;

  assign pMask = pwrMask(stb.port);
  assign rMask = rstMask(stb.port);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeHeld <= 2'd0;
      clkSel   <= 2'd0;
      pwrWord  <= pwrMask(PORT_DEV) | pwrMask(PORT_HOST);
      rstWord  <= '0;
    end else begin
      if (stb.start)   codeHeld <= rateCode(rateMhz);
      if (stb.clkLoad) clkSel   <= codeHeld;
      if (stb.pwrClr)  pwrWord  <= pwrWord & ~pMask;
      else if (stb.pwrSet) pwrWord <= pwrWord | pMask;
      if (stb.rstSet)  rstWord  <= rstWord | rMask;
      else if (stb.rstClr) rstWord <= rstWord & ~rMask;
    end
  end

  // one isolation flop per port
  for (genvar p = 0; p < 2; p++) begin : g_iso
    always_ff @(posedge clk) begin
      if (!rstN) isoOut[p] <= 1'b0;
      else if (stb.port == port_e'(p)) begin
        if (stb.isoRel)      isoOut[p] <= 1'b1;
        else if (stb.isoSet) isoOut[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (stb.loadRst)     cnt <= CNT_W'(RST_TICKS);
    else if (stb.loadSettle)  cnt <= CNT_W'(SETTLE_TICKS);
    else if (tickEn && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/usbphy_seq.sv
module usbphy_seq
  import usbphy_pkg::*;
#(
  parameter int TICK_HZ   = 1_000_000,
  parameter int RST_US    = 10,
  parameter int SETTLE_US = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [7:0] rateMhz,
  input  logic [1:0] onReq,
  input  logic [1:0] offReq,
  output logic       busy,
  output logic       done,
  output logic       rateErr,
  output logic [7:0] pwrWord,
  output logic [1:0] clkSel,
  output logic [4:0] rstWord,
  output logic [1:0] isoOut
);

  localparam longint TICK_L       = longint'(TICK_HZ);
  localparam int     RST_TICKS    = int'((longint'(RST_US) * TICK_L + 64'd999_999) / 64'd1_000_000);
  localparam int     SETTLE_TICKS = int'((longint'(SETTLE_US) * TICK_L + 64'd999_999) / 64'd1_000_000);
  localparam int     MAX_TICKS    = (RST_TICKS > SETTLE_TICKS) ? RST_TICKS : SETTLE_TICKS;
  localparam int     CNT_W        = $clog2(MAX_TICKS + 1) + 1;

  seqStb_t stb;
  logic    cntZero;

  usbphy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateMhz(rateMhz),
    .onReq(onReq), .offReq(offReq), .cntZero(cntZero), .stb(stb),
    .busy(busy), .done(done), .rateErr(rateErr)
  );

  usbphy_dp #(
    .RST_TICKS(RST_TICKS), .SETTLE_TICKS(SETTLE_TICKS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb), .rateMhz(rateMhz),
    .cntZero(cntZero), .pwrWord(pwrWord), .clkSel(clkSel),
    .rstWord(rstWord), .isoOut(isoOut)
  );

endmodule

// File: rtl/usbphy_seq_chk.sv
module usbphy_seq_chk #(
  parameter int TICK_HZ = 1_000_000,
  parameter int RST_US  = 10
) (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       busy,
  input logic       done,
  input logic       rateErr,
  input logic [7:0] pwrWord,
  input logic [4:0] rstWord,
  input logic [1:0] isoOut
);

  localparam int HOLD_TICKS = int'((longint'(RST_US) * longint'(TICK_HZ) + 64'd999_999) / 64'd1_000_000);

  logic [31:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          holdCnt <= '0;
    else if (|rstWord)  holdCnt <= holdCnt + {31'd0, tickEn};
    else                holdCnt <= '0;
  end

  // R5
  rst_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rstWord) |-> busy);

  // R5
  dev_rst_pwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstWord[0] |-> ((pwrWord & 8'h19) == 8'h00));

  // R5
  host_rst_pwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rstWord[4:3]) |-> ((pwrWord & 8'hC0) == 8'h00));

  // R6
  dev_iso_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrWord & 8'h19) != 8'h19) |-> isoOut[0]);

  // R6
  host_iso_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrWord & 8'hC0) != 8'hC0) |-> isoOut[1]);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateErr |-> (!done && $stable(pwrWord) && $stable(rstWord) && $stable(isoOut)));

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|rstWord) |-> (holdCnt == 32'(HOLD_TICKS + 1)));

endmodule

bind usbphy_seq usbphy_seq_chk #(.TICK_HZ(TICK_HZ), .RST_US(RST_US)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busy(busy), .done(done),
  .rateErr(rateErr), .pwrWord(pwrWord), .rstWord(rstWord), .isoOut(isoOut)
);

// File: tb/usbphy_seq_bench.sv
module usbphy_seq_bench;

  localparam int TICK_HZ   = 1_050_000;
  localparam int RST_US    = 10;
  localparam int SETTLE_US = 80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] rateMhz = 8'd48;
  logic [1:0] onReq = 2'b00, offReq = 2'b00;
  logic       busy, done, rateErr;
  logic [7:0] pwrWord;
  logic [1:0] clkSel;
  logic [4:0] rstWord;
  logic [1:0] isoOut;

  int checks = 0, fails = 0;
  logic [7:0] expPwr = 8'hD9;
  logic [1:0] expIso = 2'b00;
  logic [1:0] expClk = 2'd0;
  logic       tickOn = 1'b0;

  usbphy_seq #(.TICK_HZ(TICK_HZ), .RST_US(RST_US), .SETTLE_US(SETTLE_US)) u_usbphy_seq (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateMhz(rateMhz),
    .onReq(onReq), .offReq(offReq), .busy(busy), .done(done),
    .rateErr(rateErr), .pwrWord(pwrWord), .clkSel(clkSel),
    .rstWord(rstWord), .isoOut(isoOut)
  );

  always #2.5 clk = ~clk;

  function automatic int ceilTicks(int us);
    return int'((longint'(us) * longint'(TICK_HZ) + 999_999) / 1_000_000);
  endfunction

  function automatic logic [7:0] grpPwr(int p);
    return (p == 0) ? 8'h19 : 8'hC0;
  endfunction

  function automatic bit goodRate(logic [7:0] r);
    return r == 8'd12 || r == 8'd24 || r == 8'd48;
  endfunction

  function automatic logic [1:0] codeOf(logic [7:0] r);
    return (r == 8'd12) ? 2'd2 : (r == 8'd24) ? 2'd3 : 2'd0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      tickEn <= tickOn && ($urandom_range(0, 2) == 0);
    end
  end

  task automatic pulse(logic [1:0] onM, logic [1:0] offM);
    @(negedge clk);
    onReq = onM;
    offReq = offM;
    @(negedge clk);
    onReq = 2'b00;
    offReq = 2'b00;
  endtask

  task automatic compareWords(string req);
    chk(pwrWord == expPwr, req, "pwrWord", pwrWord, expPwr);
    chk(isoOut == expIso, req, "isoOut", isoOut, expIso);
    chk(clkSel == expClk, req, "clkSel", clkSel, expClk);
    chk(rstWord == 5'd0, req, "rstWord", rstWord, 0);
  endtask

  // wait for the next done; model the expected operation on port p
  task automatic waitDone(bit isOn, int p, logic [7:0] rate, string req);
    int hold = 0, settle = 0, n = 0;
    bit sawRst = 0, sawErr = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n > 5000) begin
        chk(0, req, "done timeout", n, 0);
        return;
      end
      if (rateErr) sawErr = 1;
      if (|rstWord) begin
        sawRst = 1;
        if (tickEn) hold++;
      end else if (sawRst && !done && tickEn) settle++;
      if (done) break;
    end
    chk(busy, "R12", "busy at done", busy, 1);
    chk(!sawErr, req, "unexpected rateErr", sawErr, 0);
    if (isOn) begin
      expPwr &= ~grpPwr(p);
      expIso[p] = 1'b1;
      expClk = codeOf(rate);
      chk(hold == ceilTicks(RST_US) + 1, "R7", "reset hold ticks", hold, ceilTicks(RST_US) + 1);
      chk(settle == ceilTicks(SETTLE_US) + 1, "R7", "settle ticks", settle, ceilTicks(SETTLE_US) + 1);
    end else begin
      expPwr |= grpPwr(p);
      expIso[p] = 1'b0;
      chk(!sawRst, req, "reset during power-off", sawRst, 0);
    end
    compareWords(req);
    @(negedge clk);
    chk(!done, "R12", "done width", done, 0);
  endtask

  task automatic expectErr();
    bit seen = 0, sawDone = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rateErr) seen = 1;
      if (done) sawDone = 1;
    end
    chk(seen, "R2", "rateErr raised", seen, 1);
    chk(!sawDone, "R2", "no done", sawDone, 0);
    chk(!busy, "R2", "idle after error", busy, 0);
    compareWords("R2");
  endtask

  task automatic doOp(bit isOn, int p, logic [7:0] rate);
    logic [1:0] m;
    m = 2'b00;
    m[p] = 1'b1;
    rateMhz = rate;
    if (isOn) pulse(m, 2'b00);
    else pulse(2'b00, m);
    if (isOn && !goodRate(rate)) expectErr();
    else waitDone(isOn, p, rate, (p == 0) ? "R3" : "R4");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(pwrWord == 8'hD9, "R10", "pwrWord", pwrWord, 8'hD9);
    chk(rstWord == 5'd0, "R10", "rstWord", rstWord, 0);
    chk(isoOut == 2'b00, "R10", "isoOut", isoOut, 0);
    chk(clkSel == 2'd0, "R10", "clkSel", clkSel, 0);
    chk(!busy && !done && !rateErr, "R10", "flags", {busy, done, rateErr}, 0);
    rstN = 1'b1;
    tickOn = 1'b1;

    // R1 R3 R6: device up at 12 MHz, R4 R8: host up at 24 keeps device bits
    doOp(1, 0, 8'd12);
    chk(clkSel == 2'd2, "R1", "12 MHz code", clkSel, 2);
    doOp(1, 1, 8'd24);
    chk(pwrWord[4:0] == 5'b00000 && isoOut[0], "R8", "device bits kept", pwrWord, 0);
    chk(clkSel == 2'd3, "R1", "24 MHz code", clkSel, 3);

    // R2: bad rate on device after powering it down
    doOp(0, 0, 8'd48);
    doOp(1, 0, 8'd25);

    // R9: both off at once, device first
    doOp(1, 0, 8'd48);
    chk(clkSel == 2'd0, "R1", "48 MHz code", clkSel, 0);
    pulse(2'b00, 2'b11);
    waitDone(0, 0, 8'd48, "R9");
    chk(pwrWord[7:6] == 2'b00, "R9", "host still up after first done", pwrWord[7:6], 0);
    waitDone(0, 1, 8'd48, "R9");

    // R9: both on at once, device first
    rateMhz = 8'd24;
    pulse(2'b11, 2'b00);
    waitDone(1, 0, 8'd24, "R9");
    chk(pwrWord[7:6] == 2'b11, "R9", "host still down after first done", pwrWord[7:6], 3);
    waitDone(1, 1, 8'd24, "R9");

    // R9: host off queued during device bring-up
    doOp(0, 0, 8'd24);
    rateMhz = 8'd12;
    pulse(2'b01, 2'b00);
    repeat (6) @(negedge clk);
    pulse(2'b00, 2'b10);
    waitDone(1, 0, 8'd12, "R9");
    waitDone(0, 1, 8'd12, "R9");

    // R11: on and off together for the device: off wins
    pulse(2'b01, 2'b01);
    waitDone(0, 0, 8'd12, "R11");
    chk(isoOut[0] == 1'b0, "R11", "device isolated", isoOut[0], 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] r;
      int sel;
      sel = $urandom_range(0, 4);
      r = (sel == 0) ? 8'd12 : (sel == 1) ? 8'd24 : (sel == 2) ? 8'd48 : (sel == 3) ? 8'd36 : 8'd0;
      doOp(bit'($urandom_range(0, 1)), int'($urandom_range(0, 1)), r);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150_000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule